// File: doc/BRIEF.md
# Short-Pointer Global Address Generator

This block turns a short pointer into a 64-bit global virtual address. It stores four 32-bit space registers, which are loaded through a single-entry write port. The two most significant bits of the pointer do two jobs. They give the quadrant, and they choose which space register joins the pointer offset to form the global address.

A mode input picks how the address is built. Narrow mode takes a 32-bit pointer. Wide mode takes a 64-bit pointer made of two quadrant bits, a 20-bit field that must be zero, and a 42-bit offset. A separate swizzle control widens a 32-bit address into the wide format and keeps its quadrant. The widened value then goes through the wide path.

The result is registered and appears one cycle after the request. The output stage is a three-state machine:
- **ST_IDLE**: no result since reset.
- **ST_FRESH**: a new result is on the outputs and `out_valid` is high.
- **ST_HOLD**: the last result is kept.

Transitions:
- Any state moves to ST_FRESH on `in_valid`.
- ST_FRESH falls to ST_HOLD when no request arrives.
- ST_HOLD and ST_IDLE stay put when no request arrives.

Top module: `gva_gen`

## Requirements
- R1: A synchronous reset forces `out_valid`, `out_gva`, `out_quad` and `out_malformed` to zero and clears all four space registers. After reset, a narrow request therefore returns upper GVA bits of zero.
- R2: The quadrant is the top two pointer bits. In narrow mode these are bits 31:30; in wide or swizzle mode they are bits 63:62 of the (widened) pointer. Quadrant 0, 1, 2 and 3 selects space register index 0, 1, 2 and 3 respectively, and the quadrant value appears on `out_quad`.
- R3: In narrow mode (`in_wide`=0, `in_swizzle`=0) the GVA is the selected 32-bit space value in bits 63:32 and `in_ptr[31:0]` in bits 31:0. Pointer bits 63:32 are ignored.
- R4: In wide mode (`in_wide`=1, `in_swizzle`=0), GVA bits 63:32 are the selected space value ORed with `in_ptr[63:32]`, and GVA bits 31:0 are `in_ptr[31:0]`.
- R5: In wide or swizzle mode, any set bit in pointer positions 61:42 raises `out_malformed`, and the GVA is still formed as in R4.
- R6: In wide or swizzle mode, a selected space register with any set bit in positions 9:0 raises `out_malformed`, and the GVA is still formed as in R4.
- R7: With `in_swizzle`=1, whatever `in_wide` is, the value `in_ptr[31:0]` is widened to {bits 31:30, 32 zero bits, bits 29:0}. The widened value is processed as in R4 to R6, and `in_ptr[63:32]` is ignored.
- R8: Asserting `sr_we` writes `sr_wdata` into the register chosen by `sr_idx` (0 to 3) at the clock edge. A request in the same cycle that selects that register uses the old value.
- R9: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. Back-to-back requests give back-to-back results.
- R10: With `in_valid` low, `out_gva`, `out_quad` and `out_malformed` keep their values. Space-register writes do not change them.
- R11: In narrow mode `out_malformed` is always low, whatever the space register's low bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_we | input | 1 | Space register write enable |
| sr_idx | input | 2 | Space register index (0..3) |
| sr_wdata | input | 32 | Space register write value |
| in_valid | input | 1 | Request valid |
| in_wide | input | 1 | 1 = wide 64-bit pointer, 0 = narrow 32-bit pointer |
| in_swizzle | input | 1 | Widen `in_ptr[31:0]` and use the wide path |
| in_ptr | input | 64 | Short pointer |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_gva | output | 64 | Global virtual address |
| out_quad | output | 2 | Selected quadrant / space register index |
| out_malformed | output | 1 | Reserved pointer bits or space low bits nonzero |

## Verification
The hardest case to reach is a request that reads a space register in the same cycle that register is being written. The bench drives `sr_we` and `in_valid` together on the same falling edge and targets the same index. It first checks that the result carries the old space value, then checks that the next request carries the new one. The malformed flag is reached two ways. One walk sets each reserved pointer bit in turn. A second walk rewrites one space register with each of its ten low bits set and sends both wide and narrow requests against it.

// File: rtl/gva_pkg.sv
package gva_pkg;
    localparam int PTR_W   = 64;
    localparam int NARROW_W = 32;
    localparam int SPACE_W = PTR_W - NARROW_W;
    localparam int OFF_W   = 42;
    localparam int QUAD_W  = 2;
    localparam int SR_LOW_ZERO = 10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRESH = 2'd1,
        ST_HOLD  = 2'd2
    } out_state_t;
endpackage

// File: rtl/gva_space_regs.sv
module gva_space_regs #(
    parameter int SPACE_W = 32,
    parameter int QUAD_W  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [QUAD_W-1:0]  widx,
    input  logic [SPACE_W-1:0] wdata,
    input  logic [QUAD_W-1:0]  ridx,
    output logic [SPACE_W-1:0] rdata
);
    localparam int NUM_SR = 1 << QUAD_W;

    logic [SPACE_W-1:0] bank [NUM_SR];

    for (genvar g = 0; g < NUM_SR; g++) begin : g_sr
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[g] <= '0;
            end else if (we && (widx == QUAD_W'(g))) begin
                bank[g] <= wdata;
            end
        end
    end

    // Read sees the value before any write at this edge.
    assign rdata = bank[ridx];
endmodule

// File: rtl/gva_form.sv
module gva_form #(
    parameter int PTR_W       = 64,
    parameter int NARROW_W    = 32,
    parameter int OFF_W       = 42,
    parameter int QUAD_W      = 2,
    parameter int SR_LOW_ZERO = 10
) (
    input  logic [PTR_W-1:0]          ptr,
    input  logic                      wide,
    input  logic                      swizzle,
    output logic [QUAD_W-1:0]         quad,
    input  logic [PTR_W-NARROW_W-1:0] space,
    output logic [PTR_W-1:0]          gva,
    output logic                      malformed
);
    localparam int SPACE_W = PTR_W - NARROW_W;
    localparam int KEEP_LO = NARROW_W - QUAD_W;
    localparam int GAP_W   = PTR_W - NARROW_W;
    localparam int RSV_HI  = PTR_W - QUAD_W - 1;

    logic [NARROW_W-1:0] nptr;
    logic [PTR_W-1:0]    swz;
    logic [PTR_W-1:0]    wsrc;
    logic                use_wide;
    logic                rsv_bad;
    logic                spc_bad;

    always_comb begin
        nptr     = ptr[NARROW_W-1:0];
        swz      = {nptr[NARROW_W-1 -: QUAD_W], {GAP_W{1'b0}}, nptr[KEEP_LO-1:0]};
        wsrc     = swizzle ? swz : ptr;
        use_wide = wide | swizzle;
        quad     = use_wide ? wsrc[PTR_W-1 -: QUAD_W] : nptr[NARROW_W-1 -: QUAD_W];
        rsv_bad  = |wsrc[RSV_HI:OFF_W];
        spc_bad  = |space[SR_LOW_ZERO-1:0];
        if (use_wide) begin
            gva       = {space | wsrc[PTR_W-1:NARROW_W], wsrc[NARROW_W-1:0]};
            malformed = rsv_bad | spc_bad;
        end else begin
            gva       = {space[SPACE_W-1:0], nptr};
            malformed = 1'b0;
        end
    end
endmodule

// File: rtl/gva_out_stage.sv
module gva_out_stage
    import gva_pkg::*;
#(
    parameter int PTR_W  = 64,
    parameter int QUAD_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PTR_W-1:0]  gva_d,
    input  logic [QUAD_W-1:0] quad_d,
    input  logic              mal_d,
    output logic              valid_q,
    output logic [PTR_W-1:0]  gva_q,
    output logic [QUAD_W-1:0] quad_q,
    output logic              mal_q
);
    out_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = load ? ST_FRESH : ST_IDLE;
            ST_FRESH: state_nx = load ? ST_FRESH : ST_HOLD;
            ST_HOLD:  state_nx = load ? ST_FRESH : ST_HOLD;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gva_q  <= '0;
            quad_q <= '0;
            mal_q  <= 1'b0;
        end else if (load) begin
            gva_q  <= gva_d;
            quad_q <= quad_d;
            mal_q  <= mal_d;
        end
    end

    assign valid_q = (state == ST_FRESH);
endmodule

// File: rtl/gva_gen.sv
module gva_gen
    import gva_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sr_we,
    input  logic [QUAD_W-1:0]   sr_idx,
    input  logic [SPACE_W-1:0]  sr_wdata,
    input  logic                in_valid,
    input  logic                in_wide,
    input  logic                in_swizzle,
    input  logic [PTR_W-1:0]    in_ptr,
    output logic                out_valid,
    output logic [PTR_W-1:0]    out_gva,
    output logic [QUAD_W-1:0]   out_quad,
    output logic                out_malformed
);
    logic [QUAD_W-1:0]  sel_quad;
    logic [SPACE_W-1:0] sel_space;
    logic [PTR_W-1:0]   gva_c;
    logic               mal_c;

    gva_space_regs #(.SPACE_W(SPACE_W), .QUAD_W(QUAD_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (sr_we),
        .widx  (sr_idx),
        .wdata (sr_wdata),
        .ridx  (sel_quad),
        .rdata (sel_space)
    );

    gva_form #(
        .PTR_W(PTR_W), .NARROW_W(NARROW_W), .OFF_W(OFF_W),
        .QUAD_W(QUAD_W), .SR_LOW_ZERO(SR_LOW_ZERO)
    ) u_form (
        .ptr       (in_ptr),
        .wide      (in_wide),
        .swizzle   (in_swizzle),
        .quad      (sel_quad),
        .space     (sel_space),
        .gva       (gva_c),
        .malformed (mal_c)
    );

    gva_out_stage #(.PTR_W(PTR_W), .QUAD_W(QUAD_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .load    (in_valid),
        .gva_d   (gva_c),
        .quad_d  (sel_quad),
        .mal_d   (mal_c),
        .valid_q (out_valid),
        .gva_q   (out_gva),
        .quad_q  (out_quad),
        .mal_q   (out_malformed)
    );
endmodule

// File: rtl/gva_gen_chk.sv
module gva_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_wide,
    input logic        in_swizzle,
    input logic [63:0] in_ptr,
    input logic        out_valid,
    input logic [63:0] out_gva,
    input logic [1:0]  out_quad,
    input logic        out_malformed
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_gva == 64'd0 && out_quad == 2'd0 && !out_malformed));

    p_valid_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_no_valid_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_gva) && $stable(out_quad) && $stable(out_malformed)));

    p_quad_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_wide && !in_swizzle) |=> (out_quad == $past(in_ptr[31:30])));

    p_narrow_low_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_wide && !in_swizzle) |=> (out_gva[31:0] == $past(in_ptr[31:0])));

    p_narrow_clean_r11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_wide && !in_swizzle) |=> !out_malformed);

    p_rsv_bits_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_wide && !in_swizzle && (in_ptr[61:42] != 20'd0)) |=> out_malformed);

    p_swizzle_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_swizzle) |=>
            (out_gva[29:0] == $past(in_ptr[29:0]) && out_quad == $past(in_ptr[31:30])));
endmodule

bind gva_gen gva_gen_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_wide       (in_wide),
    .in_swizzle    (in_swizzle),
    .in_ptr        (in_ptr),
    .out_valid     (out_valid),
    .out_gva       (out_gva),
    .out_quad      (out_quad),
    .out_malformed (out_malformed)
);

// File: tb/test_gva_gen.sv
`timescale 1ns/1ps
module test_gva_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sr_we = 1'b0;
    logic [1:0]  sr_idx = '0;
    logic [31:0] sr_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_wide = 1'b0;
    logic        in_swizzle = 1'b0;
    logic [63:0] in_ptr = '0;
    logic        out_valid;
    logic [63:0] out_gva;
    logic [1:0]  out_quad;
    logic        out_malformed;

    int checks = 0;
    int errors = 0;
    logic [31:0] sr_m [4];

    always #2 clk = ~clk;

    gva_gen i_gva_gen (
        .clk(clk), .rst(rst), .sr_we(sr_we), .sr_idx(sr_idx), .sr_wdata(sr_wdata),
        .in_valid(in_valid), .in_wide(in_wide), .in_swizzle(in_swizzle), .in_ptr(in_ptr),
        .out_valid(out_valid), .out_gva(out_gva), .out_quad(out_quad),
        .out_malformed(out_malformed)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] widen(input logic [63:0] p, input bit s);
        if (s) return {p[31:30], 32'h0, p[29:0]};
        return p;
    endfunction

    task automatic write_sr(input int idx, input logic [31:0] v);
        @(negedge clk);
        sr_we = 1'b1; sr_idx = 2'(idx); sr_wdata = v;
        @(negedge clk);
        sr_we = 1'b0;
        sr_m[idx] = v;
    endtask

    task automatic run(input logic [63:0] p, input bit w, input bit s, input string req);
        logic [63:0] x, eg;
        logic [1:0]  eq;
        logic        em;
        logic [31:0] sp;
        x = widen(p, s);
        if (w || s) begin
            eq = x[63:62];
            sp = sr_m[eq];
            eg = {sp | x[63:32], x[31:0]};
            em = (x[61:42] != 20'd0) || (sp[9:0] != 10'd0);
        end else begin
            eq = p[31:30];
            sp = sr_m[eq];
            eg = {sp, p[31:0]};
            em = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1; in_wide = w; in_swizzle = s; in_ptr = p;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, "valid", 64'(out_valid), 64'd1);
        chk(req, "gva", out_gva, eg);
        chk("R2", "quad", 64'(out_quad), 64'(eq));
        chk(req, "malformed", 64'(out_malformed), 64'(em));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] held;
        for (int i = 0; i < 4; i++) sr_m[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state of the outputs
        chk("R1", "valid", 64'(out_valid), 0);
        chk("R1", "gva", out_gva, 0);
        chk("R1", "quad", 64'(out_quad), 0);
        chk("R1", "malformed", 64'(out_malformed), 0);
        rst = 1'b0;
        for (int q = 0; q < 4; q++) run({32'hffffffff, 2'(q), 30'h155}, 1'b0, 1'b0, "R1");

        write_sr(0, 32'h000a0000);
        write_sr(1, 32'h00003120);
        write_sr(2, 32'h00b00abc);
        write_sr(3, 32'hfedc0123);
        run(64'h00000000_7ff33aeb, 1'b0, 1'b0, "R3");
        chk("R3", "example", out_gva, 64'h00003120_7ff33aeb);
        // R3 / R11: narrow sweep with garbage upper pointer bits
        for (int q = 0; q < 4; q++) begin
            run({32'hdeadbeef, 2'(q), 30'h0}, 1'b0, 1'b0, "R3");
            run({32'h12345678, 2'(q), 30'h3fffffff}, 1'b0, 1'b0, "R11");
            run({32'h0, 2'(q), 30'h2a5a5a5a}, 1'b0, 1'b0, "R3");
        end

        write_sr(0, 32'h0624b400);
        write_sr(1, 32'h00abc400);
        write_sr(2, 32'h7ffffc00);
        write_sr(3, 32'hfffffc00);
        run(64'h000003ff_ff7c34e8, 1'b1, 1'b0, "R4");
        chk("R4", "example", out_gva, 64'h0624b7ff_ff7c34e8);
        for (int q = 0; q < 4; q++) begin
            run({2'(q), 20'h0, 42'h0}, 1'b1, 1'b0, "R4");
            run({2'(q), 20'h0, 42'h3ffffffffff}, 1'b1, 1'b0, "R4");
            run({2'(q), 20'h0, 42'h12345abcdef}, 1'b1, 1'b0, "R4");
        end
        // R5: walk each reserved pointer bit
        for (int b = 42; b < 62; b++) begin
            run((64'(b % 4) << 62) | (64'd1 << b) | 64'h5a5, 1'b1, 1'b0, "R5");
        end
        // R7: swizzle with garbage upper bits, both mode settings
        for (int q = 0; q < 4; q++) begin
            run({32'hcafef00d, 2'(q), 30'h1234567}, 1'b0, 1'b1, "R7");
            run({32'hffffffff, 2'(q), 30'h3fffffff}, 1'b1, 1'b1, "R7");
        end
        // R6 / R11: space low bits set
        for (int b = 0; b < 10; b++) begin
            write_sr(2, 32'h0624b400 | (32'd1 << b));
            run({2'd2, 20'h0, 42'h1000}, 1'b1, 1'b0, "R6");
            run({32'h0, 2'd2, 30'h77}, 1'b0, 1'b0, "R11");
        end
        run({32'h0, 2'd2, 30'h99}, 1'b0, 1'b1, "R6");
        write_sr(2, 32'h7ffffc00);

        // R8: write and read of the same register in one cycle
        @(negedge clk);
        sr_we = 1'b1; sr_idx = 2'd3; sr_wdata = 32'h13572000;
        in_valid = 1'b1; in_wide = 1'b1; in_swizzle = 1'b0; in_ptr = {2'd3, 20'h0, 42'h42};
        @(negedge clk);
        sr_we = 1'b0; in_valid = 1'b0;
        chk("R8", "old value", out_gva, {32'hfffffc00 | 32'hc0000000, 32'h42});
        sr_m[3] = 32'h13572000;
        run({2'd3, 20'h0, 42'h42}, 1'b1, 1'b0, "R8");
        chk("R8", "new value", out_gva, {32'hd3572000, 32'h42});

        // R9 / R10: pulse and hold, writes do not disturb outputs
        held = out_gva;
        @(negedge clk);
        chk("R9", "valid drop", 64'(out_valid), 0);
        chk("R10", "gva held", out_gva, held);
        write_sr(3, 32'h0);
        sr_m[3] = 32'h0;
        repeat (3) @(negedge clk);
        chk("R10", "gva held after write", out_gva, held);
        chk("R10", "quad held", 64'(out_quad), 3);

        // R9: back-to-back requests
        @(negedge clk);
        in_valid = 1'b1; in_wide = 1'b0; in_swizzle = 1'b0; in_ptr = 64'h0000_0000_4000_0001;
        @(negedge clk);
        in_ptr = 64'h0000_0000_8000_0002;
        chk("R9", "first valid", 64'(out_valid), 1);
        chk("R9", "first gva", out_gva, {32'h00abc400, 32'h40000001});
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9", "second valid", 64'(out_valid), 1);
        chk("R9", "second gva", out_gva, {32'h7ffffc00, 32'h80000002});
        @(negedge clk);
        chk("R9", "idle valid", 64'(out_valid), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule